// File: doc/BRIEF.md
# Keyed Access Guard

The guard sits between requesters and a set of register channels that must not be touched by accident. Every channel starts out locked. To open one, software writes a key and a channel index to an unlock register. If the key matches, the index names a real channel, and no error flag is pending, that one channel opens. It stays open for a single access, and only until a programmable down-counter runs out. An access to an open channel is forwarded to a downstream port. Any other access is refused.

The outcome of every attempt is recorded in a sticky status word. Each flag stays set until software writes one to the matching bit of a clear register. While any error flag is set, further unlock attempts are aborted, so a fault cannot be silently retried.

A control bit turns refused accesses, reads of the unlock register and downstream faults into bus error responses. A live idle bit tells software that no forwarded access is pending, so it can turn the guard off safely.

Top module: `keyed_access_guard`

## Requirements
- R1: After reset the guard is off, the control register (address 0) reads zero, and the status register (address 1) reads 0x100: idle set at bit 8 and flag bits 7:0 clear.
- R2: An unlock write to address 3 opens the channel in wdata[IDX_W-1:0] when all of the following hold: the guard is on, wdata[31:24] equals KEY, the index is below NUM_CH, and no error flag is pending. The next access to that channel is then forwarded once on the downstream port with its index, write flag and data. Its read data returns on ch_rdata, and status bit 0 (success) is set.
- R3: An unlock write whose key byte differs from KEY sets status bit 3 (bad key) and opens no channel.
- R4: An unlock write that arrives while any of status bits 7:1 is set is aborted and sets status bit 5.
- R5: With timeout T in control bits [8+TMO_W-1:8], an access to the open channel is granted when it is presented on clock edge 1 through T+1 after the unlock edge. If no access is granted by edge T+1, the channel relocks at that edge and status bit 2 (expired) is set.
- R6: An access to a locked channel, or to a channel other than the open one, is not forwarded. It is acknowledged one cycle later and sets status bit 1. A granted access relocks the channel, so a second access to it is refused.
- R7: A valid unlock while a channel is open replaces it with the new channel and reloads the timer.
- R8: A read of address 3 returns zero and sets status bit 4.
- R9: With control bit 2 set, three events raise an error with the acknowledge: a read of address 3 (reg_err), a refused channel access (ch_err), and a downstream response with dn_err (ch_err). A downstream error always sets status bit 6. With bit 2 clear, no error response is raised.
- R10: A channel access or a valid-key unlock whose index is NUM_CH or above sets status bit 7, and nothing opens or is forwarded.
- R11: Writing address 2 clears each status flag whose wdata bit is one. A flag set in the same cycle as a clear of that flag stays set.
- R12: In the control register, writing bit 0 as one turns the guard on and writing bit 1 as one turns it off, dropping any open channel. While the guard is off, unlock writes are ignored, channel accesses are acknowledged without forwarding or error, and no flag is set. Status bit 8 and guard_idle are low while a forwarded access awaits its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_req | input | 1 | Register access strobe |
| reg_we | input | 1 | Register write (1) or read (0) |
| reg_addr | input | 2 | 0 control, 1 status, 2 clear, 3 unlock |
| reg_wdata | input | 32 | Register write data |
| reg_ack | output | 1 | Register access done, one cycle after the strobe |
| reg_err | output | 1 | Bus error response for the register access |
| reg_rdata | output | 32 | Register read data |
| ch_req | input | 1 | Channel access request, held until ch_ack |
| ch_we | input | 1 | Channel access is a write |
| ch_idx | input | IDX_W | Target channel index |
| ch_wdata | input | DW | Channel write data |
| ch_ack | output | 1 | Channel access done |
| ch_err | output | 1 | Bus error response for the channel access |
| ch_rdata | output | DW | Channel read data |
| dn_req | output | 1 | Forwarded access strobe, one cycle |
| dn_we | output | 1 | Forwarded write flag |
| dn_idx | output | IDX_W | Forwarded channel index |
| dn_wdata | output | DW | Forwarded write data |
| dn_rsp | input | 1 | Downstream response strobe |
| dn_err | input | 1 | Downstream error with the response |
| dn_rdata | input | DW | Downstream read data |
| guard_idle | output | 1 | No forwarded access pending |

## Verification
The bench builds the guard with four channels, a three-bit index, a three-bit timeout and a 16-bit data path. These values make every case reachable in a short run. The spare index values 4 to 7 exercise the out-of-range path. Every timeout from 0 to 7 can be swept against every access delay up to two edges past its window. All 256 key bytes can be tried, and each channel can be unlocked with a distinct downstream latency.

// File: rtl/guard_pkg.sv
package guard_pkg;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_STAT = 2'd1,
    RA_CLR  = 2'd2,
    RA_UNLK = 2'd3
  } reg_addr_e;

  localparam int FLAG_N  = 8;
  localparam int F_OK    = 0;
  localparam int F_DENY  = 1;
  localparam int F_EXP   = 2;
  localparam int F_KEY   = 3;
  localparam int F_RD    = 4;
  localparam int F_ABORT = 5;
  localparam int F_MBERR = 6;
  localparam int F_RANGE = 7;

  typedef logic [FLAG_N-1:0] flags_t;

  // every flag except the success flag blocks unlocking
  localparam flags_t ERR_MASK = 8'hFE;

endpackage

// File: rtl/guard_window.sv
module guard_window #(
  parameter int          NUM_CH = 4,
  parameter int          IDX_W  = 3,
  parameter int          TMO_W  = 8,
  parameter logic [7:0]  KEY    = 8'hA5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enabled,
  input  logic             unlk_wr,
  input  logic [7:0]       unlk_key,
  input  logic [IDX_W-1:0] unlk_idx,
  input  logic             err_pending,
  input  logic [TMO_W-1:0] timeout,
  input  logic             grant,
  output logic             open_q,
  output logic [IDX_W-1:0] open_ch_q,
  output logic             ev_abort,
  output logic             ev_key,
  output logic             ev_range,
  output logic             ev_exp
);

  localparam logic [IDX_W:0]   CH_LIMIT = NUM_CH[IDX_W:0];
  localparam logic [TMO_W-1:0] TMR_ONE  = 1;

  logic [TMO_W-1:0] tmr_q;
  logic             attempt, key_ok, in_rng, load, tmr_zero;

  always_comb begin
    attempt  = enabled & unlk_wr;
    key_ok   = (unlk_key == KEY);
    in_rng   = ({1'b0, unlk_idx} < CH_LIMIT);
    tmr_zero = (tmr_q == '0);
    // priority: pending error, then key, then index range
    ev_abort = attempt & err_pending;
    ev_key   = attempt & ~err_pending & ~key_ok;
    ev_range = attempt & ~err_pending & key_ok & ~in_rng;
    load     = attempt & ~err_pending & key_ok & in_rng;
    ev_exp   = enabled & open_q & ~load & ~grant & tmr_zero;
  end

  always_ff @(posedge clk) begin
    if (rst || !enabled) begin
      open_q    <= 1'b0;
      open_ch_q <= '0;
      tmr_q     <= '0;
    end else if (load) begin
      open_q    <= 1'b1;
      open_ch_q <= unlk_idx;
      tmr_q     <= timeout;
    end else if (open_q) begin
      if (grant || tmr_zero) begin
        open_q <= 1'b0;
      end else begin
        tmr_q <= tmr_q - TMR_ONE;
      end
    end
  end

endmodule

// File: rtl/guard_port.sv
module guard_port #(
  parameter int NUM_CH = 4,
  parameter int IDX_W  = 3,
  parameter int DW     = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enabled,
  input  logic             berren,
  input  logic             open_q,
  input  logic [IDX_W-1:0] open_ch,
  input  logic             ch_req,
  input  logic             ch_we,
  input  logic [IDX_W-1:0] ch_idx,
  input  logic [DW-1:0]    ch_wdata,
  output logic             ch_ack,
  output logic             ch_err,
  output logic [DW-1:0]    ch_rdata,
  output logic             dn_req,
  output logic             dn_we,
  output logic [IDX_W-1:0] dn_idx,
  output logic [DW-1:0]    dn_wdata,
  input  logic             dn_rsp,
  input  logic             dn_err,
  input  logic [DW-1:0]    dn_rdata,
  output logic             busy_q,
  output logic             grant,
  output logic             ev_ok,
  output logic             ev_deny,
  output logic             ev_range,
  output logic             ev_mberr
);

  localparam logic [IDX_W:0] CH_LIMIT = NUM_CH[IDX_W:0];

  logic accept, live, in_rng, hit, refuse, done;

  always_comb begin
    accept   = ch_req & ~busy_q;
    live     = accept & enabled;
    in_rng   = ({1'b0, ch_idx} < CH_LIMIT);
    hit      = open_q & (ch_idx == open_ch);
    grant    = live & in_rng & hit;
    refuse   = accept & ~grant;
    done     = busy_q & dn_rsp;
    ev_ok    = grant;
    ev_deny  = live & in_rng & ~hit;
    ev_range = live & ~in_rng;
    ev_mberr = done & dn_err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      dn_req   <= 1'b0;
      dn_we    <= 1'b0;
      dn_idx   <= '0;
      dn_wdata <= '0;
      ch_ack   <= 1'b0;
      ch_err   <= 1'b0;
      ch_rdata <= '0;
    end else begin
      dn_req <= grant;
      if (grant) begin
        dn_we    <= ch_we;
        dn_idx   <= ch_idx;
        dn_wdata <= ch_wdata;
        busy_q   <= 1'b1;
      end else if (done) begin
        busy_q <= 1'b0;
      end
      ch_ack   <= refuse | done;
      ch_err   <= berren & ((live & ~grant) | (done & dn_err));
      ch_rdata <= done ? dn_rdata : '0;
    end
  end

endmodule

// File: rtl/guard_flags.sv
module guard_flags
  import guard_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  flags_t set_vec,
  input  logic   clr_wr,
  input  flags_t clr_mask,
  output flags_t flags_q
);

  for (genvar b = 0; b < FLAG_N; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        flags_q[b] <= 1'b0;
      end else if (set_vec[b]) begin
        flags_q[b] <= 1'b1;
      end else if (clr_wr && clr_mask[b]) begin
        flags_q[b] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/keyed_access_guard.sv
module keyed_access_guard
  import guard_pkg::*;
#(
  parameter int         NUM_CH = 4,
  parameter int         IDX_W  = 3,
  parameter int         TMO_W  = 8,
  parameter int         DW     = 32,
  parameter logic [7:0] KEY    = 8'hA5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_req,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic             reg_ack,
  output logic             reg_err,
  output logic [31:0]      reg_rdata,
  input  logic             ch_req,
  input  logic             ch_we,
  input  logic [IDX_W-1:0] ch_idx,
  input  logic [DW-1:0]    ch_wdata,
  output logic             ch_ack,
  output logic             ch_err,
  output logic [DW-1:0]    ch_rdata,
  output logic             dn_req,
  output logic             dn_we,
  output logic [IDX_W-1:0] dn_idx,
  output logic [DW-1:0]    dn_wdata,
  input  logic             dn_rsp,
  input  logic             dn_err,
  input  logic [DW-1:0]    dn_rdata,
  output logic             guard_idle
);

  localparam int TMO_LSB = 8;

  logic             en_q, berren_q;
  logic [TMO_W-1:0] tmo_q;
  flags_t           flags_q, set_vec;
  logic             ctrl_wr, clr_wr, unlk_wr, unlk_rd, err_pending;
  logic             open_q, busy_q, grant;
  logic [IDX_W-1:0] open_ch_q;
  logic             w_abort, w_key, w_range, w_exp;
  logic             p_ok, p_deny, p_range, p_mberr;
  logic [31:0]      ctrl_view, stat_view;
  logic             unused_wbits;

  assign unused_wbits = ^reg_wdata;

  always_comb begin
    ctrl_wr     = reg_req & reg_we  & (reg_addr == RA_CTRL);
    clr_wr      = reg_req & reg_we  & (reg_addr == RA_CLR);
    unlk_wr     = reg_req & reg_we  & (reg_addr == RA_UNLK);
    unlk_rd     = reg_req & ~reg_we & (reg_addr == RA_UNLK);
    err_pending = |(flags_q & ERR_MASK);
  end

  // control register: enable / disable strobes, error response enable, timeout
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      berren_q <= 1'b0;
      tmo_q    <= '0;
    end else if (ctrl_wr) begin
      if (reg_wdata[1]) begin
        en_q <= 1'b0;
      end else if (reg_wdata[0]) begin
        en_q <= 1'b1;
      end
      berren_q <= reg_wdata[2];
      tmo_q    <= reg_wdata[TMO_LSB +: TMO_W];
    end
  end

  guard_window #(
    .NUM_CH(NUM_CH), .IDX_W(IDX_W), .TMO_W(TMO_W), .KEY(KEY)
  ) u_window (
    .clk        (clk),
    .rst        (rst),
    .enabled    (en_q),
    .unlk_wr    (unlk_wr),
    .unlk_key   (reg_wdata[31:24]),
    .unlk_idx   (reg_wdata[IDX_W-1:0]),
    .err_pending(err_pending),
    .timeout    (tmo_q),
    .grant      (grant),
    .open_q     (open_q),
    .open_ch_q  (open_ch_q),
    .ev_abort   (w_abort),
    .ev_key     (w_key),
    .ev_range   (w_range),
    .ev_exp     (w_exp)
  );

  guard_port #(
    .NUM_CH(NUM_CH), .IDX_W(IDX_W), .DW(DW)
  ) u_port (
    .clk     (clk),
    .rst     (rst),
    .enabled (en_q),
    .berren  (berren_q),
    .open_q  (open_q),
    .open_ch (open_ch_q),
    .ch_req  (ch_req),
    .ch_we   (ch_we),
    .ch_idx  (ch_idx),
    .ch_wdata(ch_wdata),
    .ch_ack  (ch_ack),
    .ch_err  (ch_err),
    .ch_rdata(ch_rdata),
    .dn_req  (dn_req),
    .dn_we   (dn_we),
    .dn_idx  (dn_idx),
    .dn_wdata(dn_wdata),
    .dn_rsp  (dn_rsp),
    .dn_err  (dn_err),
    .dn_rdata(dn_rdata),
    .busy_q  (busy_q),
    .grant   (grant),
    .ev_ok   (p_ok),
    .ev_deny (p_deny),
    .ev_range(p_range),
    .ev_mberr(p_mberr)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[F_OK]    = p_ok;
    set_vec[F_DENY]  = p_deny;
    set_vec[F_EXP]   = w_exp;
    set_vec[F_KEY]   = w_key;
    set_vec[F_RD]    = unlk_rd & en_q;
    set_vec[F_ABORT] = w_abort;
    set_vec[F_MBERR] = p_mberr;
    set_vec[F_RANGE] = w_range | p_range;
  end

  guard_flags u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_wr  (clr_wr),
    .clr_mask(reg_wdata[FLAG_N-1:0]),
    .flags_q (flags_q)
  );

  always_comb begin
    ctrl_view                     = '0;
    ctrl_view[0]                  = en_q;
    ctrl_view[2]                  = berren_q;
    ctrl_view[TMO_LSB +: TMO_W]   = tmo_q;
    stat_view                     = '0;
    stat_view[FLAG_N-1:0]         = flags_q;
    stat_view[FLAG_N]             = ~busy_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_ack   <= 1'b0;
      reg_err   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      reg_ack <= reg_req;
      reg_err <= unlk_rd & en_q & berren_q;
      if (reg_req && !reg_we) begin
        case (reg_addr)
          RA_CTRL: reg_rdata <= ctrl_view;
          RA_STAT: reg_rdata <= stat_view;
          default: reg_rdata <= '0;
        endcase
      end else begin
        reg_rdata <= '0;
      end
    end
  end

  assign guard_idle = ~busy_q;

endmodule

// File: rtl/guard_chk.sv
module guard_chk
  import guard_pkg::*;
#(
  parameter logic [7:0] KEY = 8'hA5
) (
  input logic        clk,
  input logic        rst,
  input logic        reg_req,
  input logic        reg_we,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        en_q,
  input logic        berren_q,
  input flags_t      flags_q,
  input logic        clr_wr,
  input logic        dn_req,
  input logic        ch_ack,
  input logic        ch_err,
  input logic        guard_idle
);

  // R8
  unlk_read_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_req && !reg_we && reg_addr == RA_UNLK && en_q) |=> flags_q[F_RD]);

  // R3
  bad_key_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_req && reg_we && reg_addr == RA_UNLK && en_q && reg_wdata[31:24] != KEY)
      |=> (flags_q[F_KEY] || flags_q[F_ABORT]));

  // R12
  off_no_forward_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !dn_req);

  // R6
  single_forward_chk: assert property (@(posedge clk) disable iff (rst)
    dn_req |=> !dn_req);

  // R9
  berr_gated_chk: assert property (@(posedge clk) disable iff (rst)
    (ch_ack && ch_err) |-> $past(berren_q));

  // R12
  pending_not_idle_chk: assert property (@(posedge clk) disable iff (rst)
    dn_req |-> !guard_idle);

  // R11
  sticky_key_chk: assert property (@(posedge clk) disable iff (rst)
    (flags_q[F_KEY] && !(clr_wr && reg_wdata[F_KEY])) |=> flags_q[F_KEY]);

endmodule

bind keyed_access_guard guard_chk #(.KEY(KEY)) i_guard_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_req   (reg_req),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .en_q      (en_q),
  .berren_q  (berren_q),
  .flags_q   (flags_q),
  .clr_wr    (clr_wr),
  .dn_req    (dn_req),
  .ch_ack    (ch_ack),
  .ch_err    (ch_err),
  .guard_idle(guard_idle)
);

// File: tb/test_keyed_access_guard.sv
module test_keyed_access_guard;

  localparam int         NUM_CH = 4;
  localparam int         IDX_W  = 3;
  localparam int         TMO_W  = 3;
  localparam int         DW     = 16;
  localparam logic [7:0] KEY    = 8'h5A;

  logic clk = 1'b0;
  always #2ns clk = ~clk;

  logic             rst;
  logic             reg_req, reg_we;
  logic [1:0]       reg_addr;
  logic [31:0]      reg_wdata, reg_rdata;
  logic             reg_ack, reg_err;
  logic             ch_req, ch_we, ch_ack, ch_err;
  logic [IDX_W-1:0] ch_idx, dn_idx;
  logic [DW-1:0]    ch_wdata, ch_rdata, dn_wdata, dn_rdata;
  logic             dn_req, dn_we, dn_rsp, dn_err, guard_idle;

  keyed_access_guard #(
    .NUM_CH(NUM_CH), .IDX_W(IDX_W), .TMO_W(TMO_W), .DW(DW), .KEY(KEY)
  ) i_keyed_access_guard (
    .clk(clk), .rst(rst),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_ack(reg_ack), .reg_err(reg_err), .reg_rdata(reg_rdata),
    .ch_req(ch_req), .ch_we(ch_we), .ch_idx(ch_idx), .ch_wdata(ch_wdata),
    .ch_ack(ch_ack), .ch_err(ch_err), .ch_rdata(ch_rdata),
    .dn_req(dn_req), .dn_we(dn_we), .dn_idx(dn_idx), .dn_wdata(dn_wdata),
    .dn_rsp(dn_rsp), .dn_err(dn_err), .dn_rdata(dn_rdata),
    .guard_idle(guard_idle)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic reg_op(input logic we, input logic [1:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic er);
    reg_req = 1'b1; reg_we = we; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    rd = reg_rdata; er = reg_err;
    check("R12 reg_ack", {31'd0, reg_ack}, 32'd1);
    reg_req = 1'b0; reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    logic [31:0] rd; logic er;
    reg_op(1'b1, a, d, rd, er);
  endtask

  task automatic rd_stat(output logic [31:0] v);
    logic er;
    reg_op(1'b0, 2'd1, 32'd0, v, er);
  endtask

  task automatic ctrl(input logic on, input logic off, input logic be, input int t);
    wr(2'd0, {16'd0, 5'd0, t[2:0], 5'd0, be, off, on});
  endtask

  task automatic unlock(input int c, input logic [7:0] k);
    wr(2'd3, {k, 16'd0, c[7:0]});
  endtask

  task automatic clear_all();
    wr(2'd2, 32'hFF);
  endtask

  task automatic ch_op(input int c, input int lat, input logic derr,
                       output logic fwd, output logic aerr, output logic [DW-1:0] rdat);
    ch_req = 1'b1; ch_idx = c[IDX_W-1:0]; ch_we = c[0]; ch_wdata = 16'hB000 + 16'(c);
    @(negedge clk);
    ch_req = 1'b0;
    if (dn_req) begin
      fwd = 1'b1;
      check("R2 dn_idx", {29'd0, dn_idx}, c);
      check("R2 dn_we", {31'd0, dn_we}, {31'd0, c[0]});
      check("R2 dn_wdata", {16'd0, dn_wdata}, 32'hB000 + c);
      check("R12 idle low while pending", {31'd0, guard_idle}, 32'd0);
      for (int i = 0; i < lat; i++) @(negedge clk);
      dn_rsp = 1'b1; dn_err = derr; dn_rdata = 16'hD000 + 16'(c);
      @(negedge clk);
      dn_rsp = 1'b0; dn_err = 1'b0; dn_rdata = '0;
    end else begin
      fwd = 1'b0;
    end
    check("R6 ch_ack", {31'd0, ch_ack}, 32'd1);
    aerr = ch_err; rdat = ch_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v; logic e, fwd, aerr; logic [DW-1:0] rdat;
    rst = 1'b1; reg_req = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    ch_req = 0; ch_we = 0; ch_idx = 0; ch_wdata = 0; dn_rsp = 0; dn_err = 0; dn_rdata = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    reg_op(1'b0, 2'd0, 0, v, e); check("R1 ctrl", v, 32'd0);
    rd_stat(v); check("R1 status", v, 32'h100);
    check("R1 idle", {31'd0, guard_idle}, 32'd1);

    // R12 off: unlock ignored, access acked without forward, no flag
    unlock(0, KEY);
    ch_op(0, 0, 0, fwd, aerr, rdat);
    check("R12 off no forward", {31'd0, fwd}, 0);
    check("R12 off no err", {31'd0, aerr}, 0);
    rd_stat(v); check("R12 off no flags", v, 32'h100);

    ctrl(1, 0, 0, 7);
    reg_op(1'b0, 2'd0, 0, v, e); check("R12 ctrl readback", v, 32'h701);

    // R2 each channel with its own latency
    for (int c = 0; c < NUM_CH; c++) begin
      unlock(c, KEY);
      ch_op(c, c, 0, fwd, aerr, rdat);
      check("R2 forwarded", {31'd0, fwd}, 1);
      check("R2 rdata", {16'd0, rdat}, 32'hD000 + c);
      rd_stat(v); check("R2 success flag", v, 32'h101);
      clear_all();
      rd_stat(v); check("R11 cleared", v, 32'h100);
    end

    // R5 timeout x delay sweep
    for (int t = 0; t < 8; t++) begin
      ctrl(1, 0, 0, t);
      for (int d = 1; d <= t + 3; d++) begin
        unlock(1, KEY);
        for (int i = 1; i < d; i++) @(negedge clk);
        ch_op(1, 0, 0, fwd, aerr, rdat);
        check("R5 window grant", {31'd0, fwd}, (d <= t + 1) ? 1 : 0);
        rd_stat(v); check("R5 window flags", v, (d <= t + 1) ? 32'h101 : 32'h106);
        clear_all();
      end
    end

    // R6 single access, locked access refused
    ctrl(1, 0, 0, 7);
    unlock(2, KEY);
    ch_op(2, 0, 0, fwd, aerr, rdat); check("R6 first granted", {31'd0, fwd}, 1);
    ch_op(2, 0, 0, fwd, aerr, rdat); check("R6 second refused", {31'd0, fwd}, 0);
    rd_stat(v); check("R6 flags", v, 32'h103);
    clear_all();
    ch_op(3, 0, 0, fwd, aerr, rdat); check("R6 locked refused", {31'd0, fwd}, 0);
    check("R9 no err when disabled", {31'd0, aerr}, 0);
    clear_all();

    // R7 replacement and reload
    unlock(0, KEY); unlock(3, KEY);
    ch_op(0, 0, 0, fwd, aerr, rdat); check("R7 old channel refused", {31'd0, fwd}, 0);
    clear_all();
    ch_op(3, 0, 0, fwd, aerr, rdat); check("R7 new channel granted", {31'd0, fwd}, 1);
    clear_all();
    ctrl(1, 0, 0, 2);
    unlock(1, KEY); @(negedge clk); @(negedge clk);
    unlock(1, KEY); @(negedge clk); @(negedge clk);
    ch_op(1, 0, 0, fwd, aerr, rdat); check("R7 timer reloaded", {31'd0, fwd}, 1);
    clear_all();
    ctrl(1, 0, 0, 7);

    // R3 key sweep
    for (int k = 0; k < 256; k++) begin
      unlock(0, k[7:0]);
      rd_stat(v); check("R3 key flags", v, (k == KEY) ? 32'h100 : 32'h108);
      ch_op(0, 0, 0, fwd, aerr, rdat);
      check("R3 key gate", {31'd0, fwd}, (k == KEY) ? 1 : 0);
      clear_all();
    end

    // R8 and R4
    reg_op(1'b0, 2'd3, 0, v, e);
    check("R8 unlock read data", v, 0); check("R8 no err berr off", {31'd0, e}, 0);
    unlock(0, KEY);
    rd_stat(v); check("R4 abort after read flag", v, 32'h130);
    ch_op(0, 0, 0, fwd, aerr, rdat); check("R4 nothing opened", {31'd0, fwd}, 0);
    clear_all();

    // R10 range
    ch_op(5, 0, 0, fwd, aerr, rdat); check("R10 access out of range", {31'd0, fwd}, 0);
    rd_stat(v); check("R10 range flag", v, 32'h180);
    unlock(6, KEY);
    rd_stat(v); check("R4 abort on range flag", v, 32'h1A0);
    clear_all();
    unlock(6, KEY);
    rd_stat(v); check("R10 unlock out of range", v, 32'h180);
    clear_all();

    // R9 error responses
    ctrl(1, 0, 1, 7);
    reg_op(1'b0, 2'd3, 0, v, e); check("R9 unlock read err", {31'd0, e}, 1);
    clear_all();
    ch_op(2, 0, 0, fwd, aerr, rdat); check("R9 locked access err", {31'd0, aerr}, 1);
    clear_all();
    unlock(2, KEY);
    ch_op(2, 1, 1, fwd, aerr, rdat); check("R9 downstream err", {31'd0, aerr}, 1);
    rd_stat(v); check("R9 master error flag", v, 32'h141);
    clear_all();
    ctrl(1, 0, 0, 7);
    unlock(2, KEY);
    ch_op(2, 1, 1, fwd, aerr, rdat); check("R9 downstream err masked", {31'd0, aerr}, 0);
    rd_stat(v); check("R9 master flag without enable", v, 32'h141);
    clear_all();

    // R11 set wins over same-cycle clear
    unlock(0, 8'h00);
    ch_req = 1'b1; ch_idx = 3'd3; ch_we = 1'b0;
    reg_req = 1'b1; reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 32'hFF;
    @(negedge clk);
    ch_req = 1'b0; reg_req = 1'b0; reg_we = 1'b0; reg_wdata = 0;
    rd_stat(v); check("R11 set wins", v, 32'h102);
    clear_all();

    // R12 idle visible in status while pending, disable drops lock
    unlock(1, KEY);
    ch_req = 1'b1; ch_idx = 3'd1; ch_we = 1'b0;
    @(negedge clk); ch_req = 1'b0;
    rd_stat(v); check("R12 status idle low", v, 32'h001);
    dn_rsp = 1'b1; @(negedge clk); dn_rsp = 1'b0;
    rd_stat(v); check("R12 status idle back", v, 32'h101);
    clear_all();
    unlock(0, KEY);
    ctrl(0, 1, 0, 7);
    ctrl(1, 0, 0, 7);
    ch_op(0, 0, 0, fwd, aerr, rdat); check("R12 disable dropped lock", {31'd0, fwd}, 0);

    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule